// File: doc/BRIEF.md
# Pin interrupt channel controller

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. It has eight channels. Each channel has a selector register that routes one pin to it. A channel works either in edge mode or in level mode. In edge mode it records rising and falling transitions in two sticky latches. In level mode it compares the pin against a programmable active level. Every pin first passes through a two-stage synchroniser.

Software reaches the block through a simple single-cycle register port. Reads are combinational on the selected word. The status word returns the live request of every channel. Writing ones to the status word has a mode-dependent side effect. An edge-mode channel loses both of its latches. A level-mode channel has its active level inverted, so one write can re-arm the channel for the opposite level. The per-channel requests and their OR leave the block as outputs for a downstream interrupt controller.

Top module: `pinint_ctrl`

## Requirements
- R1: After reset, every register word reads 0, and `irq_o` and `irq_any_o` are low.
- R2: The register words are selector at address 0, with channel n at bits 4n+3:4n; mode at address 1, where 1 means level; rise enable at address 2; fall enable at address 3; active level at address 4; and status at address 5. Address 5 holds status in bits 7:0 and reads 0 in bits 31:8. Addresses 6 and 7 read 0. Words 0 to 4 read back what was written.
- R3: Each channel observes only the pin its selector names. Activity on any other pin has no effect on its status bit.
- R4: In edge mode, a rising transition of the selected pin sets the channel's rise latch. The channel requests while the rise latch is set and its rise-enable bit is 1. The status shows this on the third clock edge after the pin changes.
- R5: In edge mode, a falling transition sets the fall latch. The channel requests while the fall latch is set and its fall-enable bit is 1.
- R6: In level mode, a channel requests while its rise-enable bit (the level enable) is 1 and the synchronised pin equals its active-level bit, where 0 means low and 1 means high. The request drops when the pin leaves that level.
- R7: Writing 1 to an edge-mode channel's status bit clears both its rise and fall latches.
- R8: Writing 1 to a level-mode channel's status bit inverts that channel's active-level bit. The change is visible at address 4.
- R9: Writing 0 to a status bit changes neither latches nor active level.
- R10: A transition detected in the same cycle as a write-one clear leaves that latch set.
- R11: `irq_o` equals the status bits, and `irq_any_o` is their OR.
- R12: A latch records a transition even while its enable is 0. Setting the enable later raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Input pins, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 8 | Per-channel request |
| irq_any_o | output | 1 | OR of all channel requests |

## Verification
The hardest situation to reach is a pin transition that is detected in exactly the cycle a write-one clear lands on the same latch. The detection happens two synchroniser stages and one edge register after the pin moves. The bench therefore changes the pin on a falling clock edge, lets two rising edges pass, and then presents the clear so that both act on the third edge. It also re-points a selector without touching the pins, to show that a reselection does not create a false edge.

// File: rtl/pinint_pkg.sv
package pinint_pkg;
  localparam int unsigned REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;
  localparam reg_addr_t RA_SEL  = 3'd0;
  localparam reg_addr_t RA_MODE = 3'd1;
  localparam reg_addr_t RA_RISE = 3'd2;
  localparam reg_addr_t RA_FALL = 3'd3;
  localparam reg_addr_t RA_ACT  = 3'd4;
  localparam reg_addr_t RA_STAT = 3'd5;
endpackage

// File: rtl/pinint_sync.sv
module pinint_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pinint_regs.sv
module pinint_regs
  import pinint_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned SELW = 4,
  parameter int unsigned DW   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  reg_addr_t           addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NCH-1:0]      stat_i,
  output logic [NCH*SELW-1:0] sel_o,
  output logic [NCH-1:0]      mode_o,
  output logic [NCH-1:0]      rise_en_o,
  output logic [NCH-1:0]      fall_en_o,
  output logic [NCH-1:0]      act_o,
  output logic [NCH-1:0]      clr_o,
  output logic [DW-1:0]       rdata_o
);
  localparam int unsigned SELFW = NCH * SELW;

  logic [SELFW-1:0] sel_q, sel_d;
  logic [NCH-1:0]   mode_q, mode_d, rise_q, rise_d, fall_q, fall_d, act_q, act_d;
  logic             stat_wr;
  logic [NCH-1:0]   ones;

  assign stat_wr = wr_i && (addr_i == RA_STAT);
  assign ones    = wdata_i[NCH-1:0];

  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    rise_d = rise_q;
    fall_d = fall_q;
    act_d  = act_q;
    if (wr_i) begin
      case (addr_i)
        RA_SEL:  sel_d  = wdata_i[SELFW-1:0];
        RA_MODE: mode_d = ones;
        RA_RISE: rise_d = ones;
        RA_FALL: fall_d = ones;
        RA_ACT:  act_d  = ones;
        RA_STAT: act_d  = act_q ^ (ones & mode_q);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      act_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      act_q  <= act_d;
    end
  end

  assign clr_o = stat_wr ? (ones & ~mode_q) : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_SEL:  rdata_o[SELFW-1:0] = sel_q;
      RA_MODE: rdata_o[NCH-1:0]   = mode_q;
      RA_RISE: rdata_o[NCH-1:0]   = rise_q;
      RA_FALL: rdata_o[NCH-1:0]   = fall_q;
      RA_ACT:  rdata_o[NCH-1:0]   = act_q;
      RA_STAT: rdata_o[NCH-1:0]   = stat_i;
      default: rdata_o = '0;
    endcase
  end

  assign sel_o     = sel_q;
  assign mode_o    = mode_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign act_o     = act_q;
endmodule

// File: rtl/pinint_chan.sv
module pinint_chan #(
  parameter int unsigned NPIN = 16,
  parameter int unsigned SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            mode_i,
  input  logic            rise_en_i,
  input  logic            fall_en_i,
  input  logic            act_i,
  input  logic            clr_i,
  output logic            req_o
);
  logic cur, old, rise_ev, fall_ev;
  logic rl_q, rl_d, fl_q, fl_d;

  assign cur     = lvl_i[sel_i];
  assign old     = prev_i[sel_i];
  assign rise_ev = cur & ~old;
  assign fall_ev = ~cur & old;

  // a fresh transition outranks a simultaneous clear
  always_comb begin
    rl_d = rise_ev | (rl_q & ~clr_i);
    fl_d = fall_ev | (fl_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q <= 1'b0;
      fl_q <= 1'b0;
    end else begin
      rl_q <= rl_d;
      fl_q <= fl_d;
    end
  end

  assign req_o = mode_i ? (rise_en_i & (cur == act_i))
                        : ((rl_q & rise_en_i) | (fl_q & fall_en_i));
endmodule

// File: rtl/pinint_ctrl.sv
module pinint_ctrl
  import pinint_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic              irq_any_o
);
  localparam int unsigned SELW = $clog2(NPIN);

  logic                rst_m, rst_q;
  logic [NPIN-1:0]     lvl, prev;
  logic [NCH*SELW-1:0] sel;
  logic [NCH-1:0]      mode, rise_en, fall_en, act, clr, req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  pinint_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_q), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev)
  );

  pinint_regs #(.NCH(NCH), .SELW(SELW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .stat_i(req), .sel_o(sel), .mode_o(mode),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .act_o(act), .clr_o(clr),
    .rdata_o(bus_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pinint_chan #(.NPIN(NPIN), .SELW(SELW)) u_ch (
      .clk(clk), .rst_n(rst_q), .lvl_i(lvl), .prev_i(prev),
      .sel_i(sel[n*SELW +: SELW]), .mode_i(mode[n]),
      .rise_en_i(rise_en[n]), .fall_en_i(fall_en[n]), .act_i(act[n]),
      .clr_i(clr[n]), .req_o(req[n])
    );
  end

  assign irq_o     = req;
  assign irq_any_o = |req;
endmodule

// File: rtl/pinint_ctrl_chk.sv
module pinint_ctrl_chk
  import pinint_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [NCH-1:0]    wlow,
  input logic [DW-1:0]     bus_rdata,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    rise_en,
  input logic [NCH-1:0]    fall_en,
  input logic [NCH-1:0]    act
);
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_STAT) |-> (bus_rdata[DW-1:NCH] == '0)); // R2

  AST_STAT_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_STAT) |-> (bus_rdata[NCH-1:0] == irq)); // R11

  AST_LVL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_STAT) |=> (act == ($past(act) ^ ($past(wlow) & $past(mode))))); // R8

  AST_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_STAT && wlow == '0) |=> $stable(act)); // R9

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == RA_STAT || bus_addr == RA_ACT)) |=> $stable(act)); // R8

  AST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~(rise_en | fall_en)) == '0)); // R4
endmodule

bind pinint_ctrl pinint_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wlow(bus_wdata[NCH-1:0]), .bus_rdata(bus_rdata), .irq(irq_o),
  .mode(mode), .rise_en(rise_en), .fall_en(fall_en), .act(act)
);

// File: tb/pinint_ctrl_test.sv
`timescale 1ns/1ps
module pinint_ctrl_test;
  import pinint_pkg::*;

  logic        clk, rst_n, bus_wr, irq_any_o;
  logic [15:0] pin_i;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  irq_o;
  int          n_run, n_fail;
  bit          done;

  pinint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_any_o(irq_any_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {pins, expected status}: channel n on pin 2n, level mode, odd channels active high
  localparam logic [23:0] VEC [7] = '{
    {16'h0000, 8'h55}, {16'h5555, 8'hAA}, {16'hFFFF, 8'hAA}, {16'hAAAA, 8'h55},
    {16'h0001, 8'h54}, {16'h0004, 8'h57}, {16'h4000, 8'hD5}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic drive(input logic [15:0] p);
    @(negedge clk);
    pin_i = p;
    settle();
  endtask

  task automatic stat_is(input string tag, input logic [7:0] exp);
    logic [31:0] v;
    rd(RA_STAT, v);
    chk(tag, v, {24'h0, exp});
    chk({tag, " R11 irq_o"}, {24'h0, irq_o}, {24'h0, exp});
    chk({tag, " R11 irq_any"}, {31'h0, irq_any_o}, {31'h0, |exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 reset word", v, 32'h0);
    end
    chk("R1 irq_o", {24'h0, irq_o}, 32'h0);
    chk("R1 irq_any", {31'h0, irq_any_o}, 32'h0);

    // R2 register map
    wr(RA_SEL, 32'h7654_3210);
    rd(RA_SEL, v);  chk("R2 sel", v, 32'h7654_3210);
    wr(RA_FALL, 32'hFFFF_FF3C);
    rd(RA_FALL, v); chk("R2 fall", v, 32'h0000_003C);
    rd(3'd6, v);    chk("R2 addr6", v, 32'h0);
    rd(3'd7, v);    chk("R2 addr7", v, 32'h0);
    wr(RA_FALL, 32'h0);

    // level table: R6, R3
    wr(RA_SEL,  32'hECA8_6420);
    wr(RA_MODE, 32'hFF);
    wr(RA_RISE, 32'hFF);
    wr(RA_ACT,  32'hAA);
    rd(RA_ACT, v); chk("R2 act", v, 32'hAA);
    for (int i = 0; i < 7; i++) begin
      drive(VEC[i][23:8]);
      stat_is($sformatf("R6 level vec %0d", i), VEC[i][7:0]);
    end

    // R8 / R9 level-mode status write
    drive(16'h0000);
    stat_is("R6 all low", 8'h55);
    wr(RA_STAT, 32'h01);
    rd(RA_ACT, v); chk("R8 act flipped", v, 32'hAB);
    stat_is("R8 ch0 now high-active", 8'h54);
    wr(RA_STAT, 32'h00);
    rd(RA_ACT, v); chk("R9 zero write keeps act", v, 32'hAB);

    // edge mode
    wr(RA_MODE, 32'h00);
    wr(RA_RISE, 32'h01);
    wr(RA_FALL, 32'h02);
    wr(RA_STAT, 32'hFF);
    stat_is("R7 clear all", 8'h00);
    drive(16'h0001);
    stat_is("R4 ch0 rise", 8'h01);
    drive(16'h0005);
    stat_is("R12 ch1 rise disabled", 8'h01);
    drive(16'h0001);
    stat_is("R5 ch1 fall", 8'h03);
    wr(RA_STAT, 32'h00);
    stat_is("R9 zero write", 8'h03);
    wr(RA_STAT, 32'h02);
    stat_is("R7 ch1 cleared", 8'h01);
    wr(RA_RISE, 32'h03);
    stat_is("R7 ch1 rise latch gone", 8'h01);
    drive(16'h0000);
    stat_is("R5 ch0 fall disabled", 8'h01);
    wr(RA_STAT, 32'h01);
    stat_is("R7 ch0 cleared", 8'h00);
    wr(RA_FALL, 32'h03);
    stat_is("R7 ch0 fall latch gone", 8'h00);

    // R12 late enable
    drive(16'h0010);
    stat_is("R12 ch2 latched, disabled", 8'h00);
    wr(RA_RISE, 32'h07);
    stat_is("R12 ch2 enabled later", 8'h04);

    // R3 reselection
    wr(RA_SEL, 32'hECA8_1420);
    wr(RA_RISE, 32'h0F);
    stat_is("R3 reselect no edge", 8'h04);
    drive(16'h0050);
    stat_is("R3 old pin ignored", 8'h04);
    drive(16'h0052);
    stat_is("R3 new pin seen", 8'h0C);

    // R10 edge coincident with clear on ch0
    @(negedge clk); pin_i = 16'h0053;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = RA_STAT; bus_wdata = 32'h01;
    @(negedge clk); bus_wr = 1'b0;
    stat_is("R10 edge beats clear", 8'h0D);
    wr(RA_STAT, 32'h01);
    stat_is("R7 later clear", 8'h0C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule